// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a fast system clock into the timing strobes that a start-stop serial transmitter and receiver need. The clock first passes through a power-of-two prescaler. The prescaler enable then steps an 8-bit up-counter that starts from a programmed reload value. Each time the counter wraps past its all-ones value it reloads and fires the 16x oversample strobe. A 4-bit counter divides that strobe by sixteen to give one strobe per bit. The bit rate is therefore f / (16 · n · (256 − P)), where n is the prescale factor and P is the reload value.

A single write port loads both settings at once. Every write restarts the prescaler, the reload counter and the divide-by-16 stage, so after reprogramming the first strobe comes a whole period later. Both strobes are one clock wide and are meant to be used as clock enables by framing logic in the same clock domain.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held, and in the cycle in which reset is released, both strobes are low. With the reset settings (P = 0, n = 1), `tick16` first goes high in cycle 255, counting the release cycle as cycle 0.
- R2: On a write, `cfg_wdata[7:0]` is taken as the reload value P and `cfg_wdata[9:8]` as the prescale select s, with n = 2^s (1, 2, 4 or 8).
- R3: When no write occurs, successive `tick16` pulses are exactly n·(256 − P) clocks apart.
- R4: A write sampled at a clock edge restarts the timing. Counting the cycle right after that edge as cycle 0, `tick16` is low up to cycle n·(256 − P) − 2 and goes high in cycle n·(256 − P) − 1.
- R5: `tick1` is high only together with `tick16`, on every 16th `tick16` pulse. After a restart the 16th pulse is the first one on which it is high.
- R6: When n·(256 − P) > 1, each `tick16` pulse lasts exactly one clock cycle.
- R7: With P = 255 and n = 1, `tick16` is high in every cycle after the write, and `tick1` is high in cycles 15, 31, and so on.
- R8: A write in the middle of a 16-pulse group clears the divide-by-16 stage, so the next `tick1` comes on the 16th `tick16` after the write.
- R9: When `cfg_we` is low, the value on `cfg_wdata` has no effect on either strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the settings register |
| cfg_wdata | input | 10 | Settings: [9:8] prescale select, [7:0] reload value |
| tick16 | output | 1 | 16x oversample strobe, one clock wide |
| tick1 | output | 1 | Bit-rate strobe, one clock wide |

## Verification
The bench measures the exact cycle of the first strobe after each write. A design with an off-by-one in its reload or wrap compare, or one that leaves the prescaler running across a write, would move that cycle by one or by up to n − 1. It runs both extreme configurations: the fastest one, where a design that inserts a reload bubble would drop strobes, and the slowest one, which exposes a truncated prescaler select. It also rewrites the settings in the middle of a 16-pulse group, where a divide-by-16 stage that is not cleared would fire `tick1` early. Finally it wiggles `cfg_wdata` with the strobe low, which catches a design that loads its settings without qualifying them with `cfg_we`.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2,
  parameter int OVS_W = 4,
  localparam int CFG_W = CNT_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             tick16,
  output logic             tick1
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] reload_q;
  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OVS_W-1:0] ovs_q;

  logic [PRE_W-1:0] pre_last;
  logic             pre_en;

  assign pre_last = ~({PRE_W{1'b1}} << sel_q);
  assign pre_en   = (pre_q == pre_last);
  assign tick16   = pre_en && (cnt_q == {CNT_W{1'b1}});
  assign tick1    = tick16 && (ovs_q == {OVS_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      sel_q    <= '0;
    end else if (cfg_we) begin
      reload_q <= cfg_wdata[CNT_W-1:0];
      sel_q    <= cfg_wdata[CFG_W-1:CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      ovs_q <= '0;
    end else if (cfg_we) begin
      pre_q <= '0;
      cnt_q <= cfg_wdata[CNT_W-1:0];
      ovs_q <= '0;
    end else begin
      pre_q <= pre_en ? '0 : pre_q + 1'b1;
      if (pre_en)
        cnt_q <= tick16 ? reload_q : cnt_q + 1'b1;
      if (tick16)
        ovs_q <= ovs_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2,
  parameter int OVS_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [CNT_W+SEL_W-1:0] cfg_wdata,
  input logic                   tick16,
  input logic                   tick1,
  input logic [CNT_W-1:0]       reload_q,
  input logic [SEL_W-1:0]       sel_q
);
  logic [OVS_W-1:0] seen_q;
  logic             fast_w;
  logic             fast_q;

  assign fast_w = (cfg_wdata[CNT_W-1:0] == {CNT_W{1'b1}}) && (cfg_wdata[CNT_W+SEL_W-1:CNT_W] == '0);
  assign fast_q = (reload_q == {CNT_W{1'b1}}) && (sel_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_we) seen_q <= '0;
    else if (tick16)      seen_q <= tick1 ? '0 : seen_q + 1'b1;
  end

  AST_RESET_QUIET:  assert property (@(posedge clk) !rst_n |-> !tick16 && !tick1); // R1
  AST_TICK1_INSIDE: assert property (@(posedge clk) disable iff (!rst_n) tick1 |-> tick16); // R5
  AST_TICK1_16TH:   assert property (@(posedge clk) disable iff (!rst_n) tick1 |-> seen_q == {OVS_W{1'b1}}); // R5
  AST_TICK1_DUE:    assert property (@(posedge clk) disable iff (!rst_n) (tick16 && seen_q == {OVS_W{1'b1}}) |-> tick1); // R8
  AST_WRITE_GAP:    assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && !fast_w) |=> !tick16); // R4
  AST_ONE_WIDE:     assert property (@(posedge clk) disable iff (!rst_n) (tick16 && !cfg_we && !fast_q) |=> !tick16); // R6
  AST_FASTEST:      assert property (@(posedge clk) disable iff (!rst_n) (fast_q && !cfg_we) |=> tick16); // R7
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W), .OVS_W(OVS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .tick16(tick16), .tick1(tick1), .reload_q(reload_q), .sel_q(sel_q)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic       tick16, tick1;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick16(tick16), .tick1(tick1)
  );

  // {prescale select, reload value}
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 8'd0},   {2'd1, 8'd200}, {2'd3, 8'd0},   {2'd2, 8'd250},
    {2'd0, 8'd255}, {2'd3, 8'd255}, {2'd0, 8'd128}, {2'd1, 8'd254}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] p);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {s, p};
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  // Observes `len` cycles starting at cycle 0 (current negedge).
  task automatic observe(input int len, input int per, output int first, output int second,
                         output int t1, output int nt_at_t1, output int wide, output int orphan);
    int nt = 0;
    bit prev = 1'b0;
    first = -1; second = -1; t1 = -1; nt_at_t1 = -1; wide = 0; orphan = 0;
    for (int k = 0; k < len; k++) begin
      if (tick1 && !tick16) orphan++;
      if (tick16) begin
        nt++;
        if (first < 0) first = k;
        else if (second < 0) second = k;
        if (prev && per > 1) wide++;
      end
      if (tick1 && t1 < 0) begin
        t1 = k;
        nt_at_t1 = nt;
      end
      prev = tick16;
      @(negedge clk);
    end
  endtask

  initial begin
    int f, s2, t1, nt1, wd, orp;
    int per;

    // R1: reset state and first tick with reset settings
    repeat (3) @(negedge clk);
    check(!tick16 && !tick1, "R1 quiet in reset", int'({tick16, tick1}), 0);
    rst_n = 1'b1;
    check(!tick16 && !tick1, "R1 quiet on release", int'({tick16, tick1}), 0);
    observe(300, 256, f, s2, t1, nt1, wd, orp);
    check(f == 255, "R1 first tick16 after reset", f, 255);

    // R2 R3 R4 R5 R6: table walk
    foreach (VEC[i]) begin
      per = (1 << VEC[i][9:8]) * (256 - int'(VEC[i][7:0]));
      wr(VEC[i][9:8], VEC[i][7:0]);
      observe(16 * per, per, f, s2, t1, nt1, wd, orp);
      check(f == per - 1, "R4 R2 first tick16 after write", f, per - 1);
      check(s2 - f == per, "R3 tick16 period", s2 - f, per);
      check(t1 == 16 * per - 1, "R5 tick1 cycle", t1, 16 * per - 1);
      check(nt1 == 16, "R5 tick16 count at tick1", nt1, 16);
      check(wd == 0, "R6 tick16 one clock wide", wd, 0);
      check(orp == 0, "R5 tick1 outside tick16", orp, 0);
    end

    // R7: fastest setting
    wr(2'd0, 8'd255);
    for (int k = 0; k < 32; k++) begin
      check(tick16 == 1'b1, "R7 tick16 every clock", int'(tick16), 1);
      check(tick1 == ((k % 16) == 15), "R7 tick1 every 16th", int'(tick1), int'((k % 16) == 15));
      @(negedge clk);
    end

    // R9: data wiggling with the strobe low changes nothing
    wr(2'd1, 8'd250);  // period 12
    repeat (5) @(negedge clk);
    cfg_wdata = {2'd0, 8'd255};
    @(negedge clk);
    cfg_wdata = {2'd3, 8'd3};
    @(negedge clk);
    cfg_wdata = '0;
    // now at cycle 7
    observe(12 * 16, 12, f, s2, t1, nt1, wd, orp);
    check(f == 4, "R9 first tick16 unaffected", f + 7, 11);
    check(s2 - f == 12, "R9 period unaffected", s2 - f, 12);

    // R8: rewrite mid-group clears divide-by-16
    wr(2'd0, 8'd250);  // period 6
    observe(6 * 5, 6, f, s2, t1, nt1, wd, orp);
    check(t1 < 0, "R8 no early tick1 before rewrite", t1, -1);
    wr(2'd0, 8'd250);
    observe(6 * 16, 6, f, s2, t1, nt1, wd, orp);
    check(t1 == 95, "R8 tick1 after rewrite", t1, 95);
    check(nt1 == 16, "R8 tick16 count after rewrite", nt1, 16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule